// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block connects two 18-bit buses, called side A and side B, through two independent storage paths: one carries A data towards B, the other carries B data towards A. Each path has three controls of its own. A drive enable decides whether the far port drives. A pass control makes the storage element transparent while it is high. A strobe input loads the element on its high-to-low transition while the pass control is low. When the pass control is low and the strobe does not fall, the element holds its contents.

The bus pins are modelled as separate input, output and output-enable signals, so the block fits a synchronous design with no tristate wires. Everything runs on one fast system clock. The pass and strobe inputs are treated as asynchronous and pass through a two-flop synchronizer, and a falling strobe is found by comparing the synchronized strobe with its value one clock earlier.

Each path is governed by a three-state controller. HOLD keeps the stored word. PASS loads the input on every clock. CAPT loads the input once, on the clock after a detected strobe fall. The next state depends only on the synchronized controls: pass high leads to PASS (transition *open*); pass low with a strobe fall leads to CAPT (transition *strobe*); pass low with no fall leads to HOLD (transition *close* when leaving PASS or CAPT, *keep* when already in HOLD). The same rules apply from every state. The stored word and the state register both update on the edge that enters the new state.

Top module: `bus_xcvr18`

## Requirements
- R1: The data path is WIDTH bits (default 18) in each direction, and every bit behaves identically (checked with all-ones and alternating 1010... patterns).
- R2: If the pass control sampled at system-clock edge m-2 was high, the output word after edge m equals the input word sampled at edge m.
- R3: With the pass control low and no strobe fall, the output word does not change, whatever the input word does.
- R4: If the strobe sampled at edge m-3 was high, the strobe sampled at edge m-2 was low, and the pass control sampled at edge m-2 was low, the output word after edge m equals the input word sampled at edge m. A rising strobe loads nothing.
- R5: A strobe fall that arrives while the pass control is high has no effect beyond transparency. After the pass control drops, the held word is the last word passed through.
- R6: The output-enable output after edge m equals the drive enable sampled at edge m (active high). Changing the drive enable never changes the stored word.
- R7: The A-to-B and B-to-A paths are fully independent. Activity on one never changes the other's output word.
- R8: When the pass control falls with no strobe fall, the held word is the input word sampled at the last edge on which the synchronized pass control was still high.
- R9: A synchronous reset clears both stored words to zero and drives both output-enable outputs low.
- R10: Both output enables may be high at the same time. No conflict check suppresses either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Word received on side A |
| a_out | output | 18 | Word presented to side A (B-to-A storage) |
| a_oe | output | 1 | Side A drive enable output |
| b_in | input | 18 | Word received on side B |
| b_out | output | 18 | Word presented to side B (A-to-B storage) |
| b_oe | output | 1 | Side B drive enable output |
| ab_drive_en | input | 1 | Enables driving of side B |
| ab_pass | input | 1 | A-to-B transparent control (async) |
| ab_strobe | input | 1 | A-to-B load strobe, falling edge (async) |
| ba_drive_en | input | 1 | Enables driving of side A |
| ba_pass | input | 1 | B-to-A transparent control (async) |
| ba_strobe | input | 1 | B-to-A load strobe, falling edge (async) |

## Verification
On every cycle the assertions check four things: in PASS and CAPT the stored word equals the input word of the previous edge, in HOLD the stored word is unchanged, and the cycle after reset shows cleared words with the enables low. What only the bench scenarios can show is the timing: that the controller reaches the right state the right number of edges after an input change. That covers a strobe fall during transparency leaving no trace, the last passed word surviving the pass control dropping, and the two paths not disturbing each other. These are compared every clock against a behavioural model with its own input-history queues.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_PASS = 2'd1,
        ST_CAPT = 2'd2
    } elem_state_t;
endpackage

// File: rtl/xcvr_sync2.sv
module xcvr_sync2 #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int WIDTH       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic             drive_en,
    input  logic             pass_en,
    input  logic             strobe,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en
);
    localparam int CTRL_W = 2;

    logic [CTRL_W-1:0] ctrl_s;
    logic              pass_s;
    logic              strobe_s;
    logic              strobe_d;
    logic              strobe_fall;
    elem_state_t       state_q;
    elem_state_t       state_n;
    logic              load;
    logic [WIDTH-1:0]  store_q;
    logic              oe_q;

    xcvr_sync2 #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pass_en, strobe}),
        .q   (ctrl_s)
    );

    assign pass_s      = ctrl_s[1];
    assign strobe_s    = ctrl_s[0];
    assign strobe_fall = strobe_d & ~strobe_s;

    always_ff @(posedge clk) begin
        if (rst) strobe_d <= 1'b0;
        else     strobe_d <= strobe_s;
    end

    // Next-state logic: the same rules from every state
    always_comb begin
        state_n = ST_HOLD;
        unique case (state_q)
            ST_HOLD: begin
                if (pass_s)           state_n = ST_PASS;   // open
                else if (strobe_fall) state_n = ST_CAPT;   // strobe
                else                  state_n = ST_HOLD;   // keep
            end
            ST_PASS: begin
                if (pass_s)           state_n = ST_PASS;   // stay open
                else if (strobe_fall) state_n = ST_CAPT;   // strobe
                else                  state_n = ST_HOLD;   // close
            end
            ST_CAPT: begin
                if (pass_s)           state_n = ST_PASS;   // open
                else if (strobe_fall) state_n = ST_CAPT;   // strobe again
                else                  state_n = ST_HOLD;   // close
            end
            default:                  state_n = ST_HOLD;
        endcase
    end

    assign load = (state_n != ST_HOLD);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_n;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
            oe_q    <= 1'b0;
        end else begin
            if (load) store_q <= din;
            oe_q <= drive_en;
        end
    end

    assign dout    = store_q;
    assign dout_en = oe_q;

    p_pass_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PASS) |-> (dout == $past(din)));

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && state_q == ST_HOLD) |-> (dout == $past(dout)));

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPT) |-> (dout == $past(din)));

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dout == '0 && !dout_en && state_q == ST_HOLD));
endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18 #(
    parameter int WIDTH       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ab_drive_en,
    input  logic             ab_pass,
    input  logic             ab_strobe,
    input  logic             ba_drive_en,
    input  logic             ba_pass,
    input  logic             ba_strobe
);
    xcvr_lane #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_a2b (
        .clk      (clk),
        .rst      (rst),
        .din      (a_in),
        .drive_en (ab_drive_en),
        .pass_en  (ab_pass),
        .strobe   (ab_strobe),
        .dout     (b_out),
        .dout_en  (b_oe)
    );

    xcvr_lane #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_b2a (
        .clk      (clk),
        .rst      (rst),
        .din      (b_in),
        .drive_en (ba_drive_en),
        .pass_en  (ba_pass),
        .strobe   (ba_strobe),
        .dout     (a_out),
        .dout_en  (a_oe)
    );

    // R7: with the B-to-A controls idle and held low, side A output stays put
    p_dir_indep_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ba_pass) && !$past(ba_pass, 2) && !$past(ba_pass, 3)
         && !$past(ba_strobe) && !$past(ba_strobe, 2) && !$past(ba_strobe, 3)
         && !$past(ba_strobe, 4))
        |-> (a_out == $past(a_out)));
endmodule

// File: tb/bus_xcvr18_tb_top.sv
module bus_xcvr18_tb_top;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic         ab_drive_en = 0, ab_pass = 0, ab_strobe = 0;
    logic         ba_drive_en = 0, ba_pass = 0, ba_strobe = 0;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur_tag = "R9";

    always #4 clk = ~clk;

    bus_xcvr18 #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_drive_en(ab_drive_en), .ab_pass(ab_pass), .ab_strobe(ab_strobe),
        .ba_drive_en(ba_drive_en), .ba_pass(ba_pass), .ba_strobe(ba_strobe)
    );

    // Behavioural reference model with input-history queues
    bit           lh_ab[$], ch_ab[$], lh_ba[$], ch_ba[$];
    logic [W-1:0] m_b, m_a;
    logic         m_boe, m_aoe;

    always @(posedge clk) begin
        if (rst) begin
            lh_ab = '{0, 0};    ch_ab = '{0, 0, 0};
            lh_ba = '{0, 0};    ch_ba = '{0, 0, 0};
            m_b = '0; m_a = '0; m_boe = 0; m_aoe = 0;
        end else begin
            if (lh_ab[0] || (ch_ab[0] && !ch_ab[1])) m_b = a_in;
            if (lh_ba[0] || (ch_ba[0] && !ch_ba[1])) m_a = b_in;
            m_boe = ab_drive_en;
            m_aoe = ba_drive_en;
            void'(lh_ab.pop_front()); lh_ab.push_back(ab_pass);
            void'(ch_ab.pop_front()); ch_ab.push_back(ab_strobe);
            void'(lh_ba.pop_front()); lh_ba.push_back(ba_pass);
            void'(ch_ba.pop_front()); ch_ba.push_back(ba_strobe);
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({cur_tag, " b_out"}, b_out, m_b);
            check({cur_tag, " a_out"}, a_out, m_a);
            check({cur_tag, " b_oe"}, W'(b_oe), W'(m_boe));
            check({cur_tag, " a_oe"}, W'(a_oe), W'(m_aoe));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] alt_pat();
        logic [W-1:0] p;
        for (int i = 0; i < W; i++) p[i] = i[0];
        return p;
    endfunction

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    localparam logic [W-1:0] P1 = 18'h0A5C3, P2 = 18'h3F00F, P3 = 18'h12345,
                             P4 = 18'h2BEEF, P5 = 18'h05555, P6 = 18'h3C3C3,
                             P7 = 18'h1D00D, P8 = 18'h27777, P9 = 18'h0F0F1,
                             Q1 = 18'h31313, Q2 = 18'h0ACED;

    initial begin
        tick(5);
        rst = 0;
        tick(1);
        // R9: reset state
        check("R9 b_out", b_out, '0);
        check("R9 a_out", a_out, '0);
        check("R9 oe", W'({a_oe, b_oe}), '0);

        // R2: transparent A-to-B
        cur_tag = "R2";
        ab_pass = 1; a_in = P1; tick(4);
        check("R2 follow", b_out, P1);
        a_in = P2; tick(1);
        check("R2 same-edge", b_out, P2);

        // R1: every bit channel
        cur_tag = "R1";
        a_in = '1; tick(2);
        check("R1 ones", b_out, '1);
        a_in = alt_pat(); tick(2);
        check("R1 alternating", b_out, alt_pat());
        a_in = ~alt_pat(); tick(2);
        check("R1 inverted", b_out, ~alt_pat());

        // R8: last passed word kept after pass drops
        cur_tag = "R8";
        a_in = P3; tick(3);
        ab_pass = 0; tick(3);
        a_in = P4; tick(4);
        check("R8 last passed", b_out, P3);

        // R3: hold with steady strobe
        cur_tag = "R3";
        a_in = P5; tick(5);
        check("R3 hold", b_out, P3);

        // R4: rising strobe loads nothing, falling strobe captures
        cur_tag = "R4";
        ab_strobe = 1; tick(4);
        check("R4 rising no load", b_out, P3);
        ab_strobe = 0; tick(5);
        check("R4 fall capture", b_out, P5);
        a_in = P6; tick(4);
        check("R3 hold after capture", b_out, P5);

        // R5: strobe fall during transparency
        cur_tag = "R5";
        ab_pass = 1; a_in = P7; tick(4);
        ab_strobe = 1; tick(3);
        ab_strobe = 0; tick(1);
        a_in = P8; tick(4);
        check("R5 fall while open", b_out, P8);
        a_in = P7; tick(3);
        ab_pass = 0; tick(3);
        a_in = P1; tick(5);
        check("R5 no leftover capture", b_out, P7);

        // R6: output enable, stored word unaffected
        cur_tag = "R6";
        ab_drive_en = 1; tick(1);
        check("R6 oe on", W'(b_oe), W'(1'b1));
        ab_drive_en = 0; ab_pass = 1; a_in = P9; tick(4);
        check("R6 oe off", W'(b_oe), W'(1'b0));
        ab_pass = 0; tick(3);
        a_in = P2; tick(3);
        ab_drive_en = 1; tick(3);
        check("R6 word kept", b_out, P9);

        // R7: B-to-A path, independent of A-to-B
        cur_tag = "R7";
        ba_pass = 1; b_in = Q1; a_in = P4; tick(4);
        check("R7 a_out follows", a_out, Q1);
        check("R7 b_out untouched", b_out, P9);
        ab_pass = 1; ba_pass = 0; tick(4);
        ba_strobe = 1; tick(4);
        b_in = Q2; ba_strobe = 0; tick(5);
        check("R7 ba capture", a_out, Q2);
        check("R7 ab open", b_out, P4);
        ab_pass = 0; tick(4);

        // R10: both enables at once
        cur_tag = "R10";
        ab_drive_en = 1; ba_drive_en = 1; tick(2);
        check("R10 both oe", W'({a_oe, b_oe}), W'(2'b11));

        // R9: reset mid-run
        cur_tag = "R9";
        rst = 1; tick(3);
        rst = 0; ab_drive_en = 0; ba_drive_en = 0; tick(1);
        check("R9 re-reset b", b_out, '0);
        check("R9 re-reset a", a_out, '0);
        check("R9 re-reset oe", W'({a_oe, b_oe}), '0);
        tick(2);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule